// File: doc/BRIEF.md
# Configuration Switch Override Register Block

This block sits in a board-control FPGA. It holds a small byte-wide register map that lets software replace the value of any bit of eight 8-bit physical configuration switches. Each switch has a shadow byte and a per-bit enable byte. Where an enable bit is set, the shadow bit takes the place of the physical bit in the effective switch vector. Where it is clear, the synchronized physical bit passes through.

Two write-triggered board resets are provided. A write to the plain reset register produces a fixed-length reset pulse during which only the physical switches are captured. An arm-then-fire sequence on the control register produces the same pulse, but it captures the effective (overridden) vector. The captured vector is held on a sampled-configuration output after the pulse. The boot-bank field of switch 7 is decoded into a virtual bank number and an emulator-select flag. The identification bytes read back as constants. The six clock-setting bytes are plain read/write storage.

Top module: `swov_top`

## Requirements
- R1: For every bit, `eff_sw` equals the shadow bit when the matching enable bit is 1 and the synchronized physical bit when it is 0.
- R2: Switch x (1..8) has its shadow byte at offset 0x20+2*(x-1) and its enable byte at 0x21+2*(x-1). Both are readable and writable. Switch x occupies bits [8*(x-1)+7 : 8*(x-1)] of every 64-bit switch vector.
- R3: A write of any value to offset 0x04 starts a board reset that captures only the synchronized physical switches, whatever the enable bits hold. Offset 0x04 reads as 0x00.
- R4: A write to control offset 0x10 with bit 0 = 1, while the stored control bit 0 is 0, starts a board reset that captures the effective vector. A write of 1 while the stored bit 0 is already 1 starts nothing. The control byte reads back its stored value.
- R5: `board_rst` is high for exactly RST_CYCLES clock cycles (default 4), starting the cycle after the triggering write. Triggers that arrive while it is high are ignored.
- R6: `cfg_sampled` is captured during the pulse and stays unchanged while `board_rst` is low.
- R7: The boot field is bits 7:4 of switch 7 in `cfg_sampled`. A field value below 8 gives `boot_emul` = 0 and `boot_vbank` = field[1:0]. A value of 8 or more gives `boot_emul` = 1.
- R8: Offsets 0x00, 0x01 and 0x02 read the BOARD_ID, ARCH_VER and FPGA_VER parameters. Writes to them have no effect.
- R9: Offsets 0x19 to 0x1E are six independent read/write storage bytes that reset to 0x00.
- R10: Offsets not named in R2, R3, R4, R8 and R9 read 0x00, and writes to them change no register.
- R11: After `rst_n`, all shadow and enable bytes read 0x00 and `board_rst` and `cfg_sampled` are 0. Shadow and enable bytes keep their values through a board reset.
- R12: A change on `phys_sw` reaches `eff_sw` on the second rising clock edge after it, not the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 6 | Byte offset for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| phys_sw | input | 64 | Physical switch bits, asynchronous |
| eff_sw | output | 64 | Effective switch vector after override |
| board_rst | output | 1 | Board reset pulse |
| cfg_sampled | output | 64 | Switch vector captured during the last pulse |
| boot_vbank | output | 2 | Virtual boot bank from the captured field |
| boot_emul | output | 1 | Captured field selects the boot emulator |

## Verification
The override multiplexer is driven with all enables clear, all enables set, and two mixed enable masks. This distinguishes a per-bit selection from a per-byte one or an inverted one. Each switch gets a distinct shadow and enable value, so that swapped or mis-decoded offsets show up. The two reset paths are run against the same switch-7 setup, with the physical field and the shadow field different. Only the choice of captured source can then explain the decoded bank. A re-trigger during a pulse and a repeated control write of 1 separate edge-armed triggering from level triggering.

// File: rtl/swov_pkg.sv
package swov_pkg;
  localparam int OFS_ID      = 'h00;
  localparam int OFS_ARCH    = 'h01;
  localparam int OFS_FVER    = 'h02;
  localparam int OFS_PRST    = 'h04;
  localparam int OFS_CTRL    = 'h10;
  localparam int OFS_CLK     = 'h19;
  localparam int N_CLK       = 6;
  localparam int OFS_SW_BASE = 'h20;

  typedef enum logic {CAP_PHYS = 1'b0, CAP_EFF = 1'b1} cap_src_e;
endpackage

// File: rtl/swov_sync.sv
module swov_sync #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] meta_q;
  logic [W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= d_async;
      hold_q <= meta_q;
    end
  end

  assign d_sync = hold_q;
endmodule

// File: rtl/swov_regs.sv
module swov_regs
  import swov_pkg::*;
#(
  parameter int         N_SW     = 8,
  parameter int         SW_W     = 8,
  parameter int         ADDR_W   = 6,
  parameter logic [7:0] BOARD_ID = 8'h5A,
  parameter logic [7:0] ARCH_VER = 8'h13,
  parameter logic [7:0] FPGA_VER = 8'h07
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [7:0]           wdata,
  output logic [7:0]           rdata,
  output logic [N_SW*SW_W-1:0] shadow_flat,
  output logic [N_SW*SW_W-1:0] enable_flat,
  output logic                 trig_plain,
  output logic                 trig_ovr
);
  localparam logic [ADDR_W-1:0] A_ID   = ADDR_W'(OFS_ID);
  localparam logic [ADDR_W-1:0] A_ARCH = ADDR_W'(OFS_ARCH);
  localparam logic [ADDR_W-1:0] A_FVER = ADDR_W'(OFS_FVER);
  localparam logic [ADDR_W-1:0] A_PRST = ADDR_W'(OFS_PRST);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_CLK  = ADDR_W'(OFS_CLK);
  localparam logic [ADDR_W-1:0] A_SW   = ADDR_W'(OFS_SW_BASE);

  logic [SW_W-1:0] shadow_q [N_SW];
  logic [SW_W-1:0] shadow_d [N_SW];
  logic [SW_W-1:0] enable_q [N_SW];
  logic [SW_W-1:0] enable_d [N_SW];
  logic [7:0]      clkb_q   [N_CLK];
  logic [7:0]      clkb_d   [N_CLK];
  logic [7:0]      ctrl_q, ctrl_d;

  logic [ADDR_W-1:0] sw_off, clk_off;
  logic              sw_hit, clk_hit;

  assign sw_off  = addr - A_SW;
  assign clk_off = addr - A_CLK;
  assign sw_hit  = (addr >= A_SW)  && (sw_off  < ADDR_W'(2*N_SW));
  assign clk_hit = (addr >= A_CLK) && (clk_off < ADDR_W'(N_CLK));

  // next-state
  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en && addr == A_CTRL) ctrl_d = wdata;
    for (int i = 0; i < N_SW; i++) begin
      shadow_d[i] = shadow_q[i];
      enable_d[i] = enable_q[i];
      if (wr_en && sw_hit && sw_off[ADDR_W-1:1] == (ADDR_W-1)'(i)) begin
        if (sw_off[0]) enable_d[i] = wdata[SW_W-1:0];
        else           shadow_d[i] = wdata[SW_W-1:0];
      end
    end
    for (int k = 0; k < N_CLK; k++) begin
      clkb_d[k] = clkb_q[k];
      if (wr_en && clk_hit && clk_off == ADDR_W'(k)) clkb_d[k] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      for (int i = 0; i < N_SW; i++) begin
        shadow_q[i] <= '0;
        enable_q[i] <= '0;
      end
      for (int k = 0; k < N_CLK; k++) clkb_q[k] <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      for (int i = 0; i < N_SW; i++) begin
        shadow_q[i] <= shadow_d[i];
        enable_q[i] <= enable_d[i];
      end
      for (int k = 0; k < N_CLK; k++) clkb_q[k] <= clkb_d[k];
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    if      (addr == A_ID)   rdata = BOARD_ID;
    else if (addr == A_ARCH) rdata = ARCH_VER;
    else if (addr == A_FVER) rdata = FPGA_VER;
    else if (addr == A_CTRL) rdata = ctrl_q;
    for (int k = 0; k < N_CLK; k++)
      if (clk_hit && clk_off == ADDR_W'(k)) rdata = clkb_q[k];
    for (int i = 0; i < N_SW; i++)
      if (sw_hit && sw_off[ADDR_W-1:1] == (ADDR_W-1)'(i))
        rdata = 8'(sw_off[0] ? enable_q[i] : shadow_q[i]);
  end

  generate
    for (genvar g = 0; g < N_SW; g++) begin : g_flat
      assign shadow_flat[g*SW_W +: SW_W] = shadow_q[g];
      assign enable_flat[g*SW_W +: SW_W] = enable_q[g];
    end
  endgenerate

  assign trig_plain = wr_en && (addr == A_PRST);
  assign trig_ovr   = wr_en && (addr == A_CTRL) && wdata[0] && !ctrl_q[0];
endmodule

// File: rtl/swov_rstseq.sv
module swov_rstseq
  import swov_pkg::*;
#(
  parameter int W          = 64,
  parameter int RST_CYCLES = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         trig_plain,
  input  logic         trig_ovr,
  input  logic [W-1:0] phys_vec,
  input  logic [W-1:0] eff_vec,
  output logic         pulse,
  output logic [W-1:0] sampled
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  cap_src_e         src_q, src_d;
  logic [W-1:0]     samp_q, samp_d;
  logic             busy, start;

  assign busy  = (cnt_q != '0);
  assign start = !busy && (trig_plain || trig_ovr);

  always_comb begin
    cnt_d  = cnt_q;
    src_d  = src_q;
    samp_d = samp_q;
    if (start) begin
      cnt_d = CNT_W'(RST_CYCLES);
      src_d = trig_ovr ? CAP_EFF : CAP_PHYS;
    end else if (busy) begin
      cnt_d = cnt_q - 1'b1;
    end
    if (busy) samp_d = (src_q == CAP_EFF) ? eff_vec : phys_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      src_q  <= CAP_PHYS;
      samp_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      src_q  <= src_d;
      samp_q <= samp_d;
    end
  end

  assign pulse   = busy;
  assign sampled = samp_q;
endmodule

// File: rtl/swov_top.sv
module swov_top #(
  parameter int         N_SW       = 8,
  parameter int         SW_W       = 8,
  parameter int         ADDR_W     = 6,
  parameter int         RST_CYCLES = 4,
  parameter int         BANK_SW    = 7,
  parameter int         BANK_LSB   = 4,
  parameter int         BANK_W     = 4,
  parameter logic [7:0] BOARD_ID   = 8'h5A,
  parameter logic [7:0] ARCH_VER   = 8'h13,
  parameter logic [7:0] FPGA_VER   = 8'h07
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [7:0]           bus_wdata,
  output logic [7:0]           bus_rdata,
  input  logic [N_SW*SW_W-1:0] phys_sw,
  output logic [N_SW*SW_W-1:0] eff_sw,
  output logic                 board_rst,
  output logic [N_SW*SW_W-1:0] cfg_sampled,
  output logic [1:0]           boot_vbank,
  output logic                 boot_emul
);
  localparam int VEC_W    = N_SW * SW_W;
  localparam int FIELD_LO = (BANK_SW - 1) * SW_W + BANK_LSB;

  logic [1:0]       rsync_q;
  logic             rst_int_n;
  logic [VEC_W-1:0] phys_s, shadow_v, enable_v;
  logic             trig_plain, trig_ovr;
  logic [BANK_W-1:0] boot_field;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  swov_sync #(.W(VEC_W)) sync_i (
    .clk(clk), .rst_n(rst_int_n), .d_async(phys_sw), .d_sync(phys_s)
  );

  swov_regs #(
    .N_SW(N_SW), .SW_W(SW_W), .ADDR_W(ADDR_W),
    .BOARD_ID(BOARD_ID), .ARCH_VER(ARCH_VER), .FPGA_VER(FPGA_VER)
  ) regs_i (
    .clk(clk), .rst_n(rst_int_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata),
    .shadow_flat(shadow_v), .enable_flat(enable_v),
    .trig_plain(trig_plain), .trig_ovr(trig_ovr)
  );

  // per-bit override selection
  generate
    for (genvar b = 0; b < VEC_W; b++) begin : g_ovr
      assign eff_sw[b] = enable_v[b] ? shadow_v[b] : phys_s[b];
    end
  endgenerate

  swov_rstseq #(.W(VEC_W), .RST_CYCLES(RST_CYCLES)) seq_i (
    .clk(clk), .rst_n(rst_int_n),
    .trig_plain(trig_plain), .trig_ovr(trig_ovr),
    .phys_vec(phys_s), .eff_vec(eff_sw),
    .pulse(board_rst), .sampled(cfg_sampled)
  );

  assign boot_field = cfg_sampled[FIELD_LO +: BANK_W];
  assign boot_emul  = (boot_field >= BANK_W'(1 << (BANK_W - 1)));
  assign boot_vbank = boot_field[1:0];
endmodule

// File: rtl/swov_chk.sv
module swov_chk #(
  parameter int         ADDR_W     = 6,
  parameter int         VEC_W      = 64,
  parameter int         RST_CYCLES = 4,
  parameter logic [7:0] BOARD_ID   = 8'h5A
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_rdata,
  input logic              board_rst,
  input logic [VEC_W-1:0]  cfg_sampled
);
  int hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hi_cnt <= 0;
    else if (board_rst) hi_cnt <= hi_cnt + 1;
    else                hi_cnt <= 0;
  end

  logic unmapped;
  assign unmapped = (bus_addr == 6'h03) ||
                    (bus_addr >= 6'h05 && bus_addr <= 6'h0F) ||
                    (bus_addr >= 6'h11 && bus_addr <= 6'h18) ||
                    (bus_addr == 6'h1F);

  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(board_rst) |-> hi_cnt == RST_CYCLES); // R5
  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(board_rst) |-> $past(bus_wr && (bus_addr == 6'h04 || bus_addr == 6'h10))); // R3
  AST_SAMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!board_rst && !$past(board_rst)) |-> $stable(cfg_sampled)); // R6
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |-> bus_rdata == 8'h00); // R10
  AST_ID_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == 6'h00 |-> bus_rdata == BOARD_ID); // R8
endmodule

bind swov_top swov_chk #(
  .ADDR_W(ADDR_W), .VEC_W(N_SW*SW_W), .RST_CYCLES(RST_CYCLES), .BOARD_ID(BOARD_ID)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .board_rst(board_rst), .cfg_sampled(cfg_sampled)
);

// File: tb/swov_top_tb_top.sv
`timescale 1ns/1ps
module swov_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [5:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [63:0] phys_sw, eff_sw, cfg_sampled;
  logic        board_rst;
  logic [1:0]  boot_vbank;
  logic        boot_emul;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  swov_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .phys_sw(phys_sw),
    .eff_sw(eff_sw), .board_rst(board_rst), .cfg_sampled(cfg_sampled),
    .boot_vbank(boot_vbank), .boot_emul(boot_emul)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // counts remaining high cycles of board_rst, sampled at negedges
  task automatic pulse_len(output int n);
    n = 0;
    while (board_rst && n < 50) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset_state();
    logic [7:0] d;
    chk("R11", "board_rst", 64'(board_rst), 64'd0);
    chk("R11", "cfg_sampled", cfg_sampled, 64'd0);
    for (int x = 1; x <= 8; x++) begin
      rd(6'(32 + 2*(x-1)), d); chk("R11", "shadow reset", 64'(d), 64'd0);
      rd(6'(33 + 2*(x-1)), d); chk("R11", "enable reset", 64'(d), 64'd0);
    end
    chk("R1", "eff with no enables", eff_sw, phys_sw);
  endtask

  task automatic t_ident();
    logic [7:0] d;
    rd(6'h00, d); chk("R8", "board id", 64'(d), 64'h5A);
    rd(6'h01, d); chk("R8", "arch ver", 64'(d), 64'h13);
    rd(6'h02, d); chk("R8", "fpga ver", 64'(d), 64'h07);
    wr(6'h00, 8'hFF);
    rd(6'h00, d); chk("R8", "id after write", 64'(d), 64'h5A);
  endtask

  task automatic t_map();
    logic [7:0] d;
    for (int x = 1; x <= 8; x++) begin
      wr(6'(32 + 2*(x-1)), 8'(8'h10 * x + x));
      wr(6'(33 + 2*(x-1)), 8'(8'hC0 ^ x));
    end
    for (int x = 1; x <= 8; x++) begin
      rd(6'(32 + 2*(x-1)), d); chk("R2", "shadow readback", 64'(d), 64'(8'(8'h10 * x + x)));
      rd(6'(33 + 2*(x-1)), d); chk("R2", "enable readback", 64'(d), 64'(8'(8'hC0 ^ x)));
    end
  endtask

  task automatic load_all(input logic [63:0] sh, input logic [63:0] en);
    for (int x = 1; x <= 8; x++) begin
      wr(6'(32 + 2*(x-1)), sh[(x-1)*8 +: 8]);
      wr(6'(33 + 2*(x-1)), en[(x-1)*8 +: 8]);
    end
  endtask

  task automatic t_mux(input logic [63:0] sh, input logic [63:0] en, input logic [63:0] ph);
    phys_sw = ph;
    load_all(sh, en);
    idle(3);
    chk("R1", "effective vector", eff_sw, (sh & en) | (ph & ~en));
  endtask

  task automatic t_sync();
    load_all(64'h0, 64'h0);
    phys_sw = 64'h0123_4567_89AB_CDEF;
    idle(3);
    phys_sw = ~64'h0123_4567_89AB_CDEF;
    @(posedge clk); @(negedge clk);
    chk("R12", "after one edge", eff_sw, 64'h0123_4567_89AB_CDEF);
    @(posedge clk); @(negedge clk);
    chk("R12", "after two edges", eff_sw, ~64'h0123_4567_89AB_CDEF);
  endtask

  task automatic t_boot_paths();
    int n;
    logic [7:0] d;
    load_all(64'h0, 64'h0);
    phys_sw = 64'h0000_0000_0000_0000;
    phys_sw[55:48] = 8'h5C;            // switch 7, field 5
    wr(6'h2C, 8'h2A);                  // switch 7 shadow, field 2
    wr(6'h2D, 8'hF0);                  // switch 7 enable on field bits
    idle(3);
    wr(6'h04, 8'h77);
    pulse_len(n);
    chk("R5", "plain pulse length", 64'(n), 64'd4);
    chk("R3", "plain capture", cfg_sampled, phys_sw);
    chk("R7", "vbank phys", 64'(boot_vbank), 64'd1);
    chk("R7", "emul phys", 64'(boot_emul), 64'd0);
    wr(6'h10, 8'h00);
    wr(6'h10, 8'h01);
    pulse_len(n);
    chk("R5", "override pulse length", 64'(n), 64'd4);
    chk("R4", "override capture", cfg_sampled[55:48], 64'h2C);
    chk("R7", "vbank override", 64'(boot_vbank), 64'd2);
    idle(5);
    chk("R6", "held after pulse", cfg_sampled[55:48], 64'h2C);
    rd(6'h2C, d); chk("R11", "shadow kept", 64'(d), 64'h2A);
    rd(6'h2D, d); chk("R11", "enable kept", 64'(d), 64'hF0);
    rd(6'h10, d); chk("R4", "ctrl readback", 64'(d), 64'h01);
    rd(6'h04, d); chk("R3", "reset reg reads zero", 64'(d), 64'h00);
    wr(6'h10, 8'h01);
    idle(1);
    chk("R4", "no pulse on repeated 1", 64'(board_rst), 64'd0);
    wr(6'h2D, 8'h00);
    phys_sw[55:48] = 8'hC3;            // field 0xC
    idle(3);
    wr(6'h04, 8'h00);
    pulse_len(n);
    chk("R7", "emul high", 64'(boot_emul), 64'd1);
  endtask

  task automatic t_retrigger();
    int n;
    wr(6'h04, 8'h01);
    wr(6'h04, 8'h01);                  // during pulse: ignored
    pulse_len(n);
    chk("R5", "retrigger ignored", 64'(n), 64'd3);
  endtask

  task automatic t_clk_and_unmapped();
    logic [7:0] d;
    for (int k = 0; k < 6; k++) wr(6'(6'h19 + k), 8'(8'hA0 + k));
    for (int k = 0; k < 6; k++) begin
      rd(6'(6'h19 + k), d); chk("R9", "clock byte", 64'(d), 64'(8'(8'hA0 + k)));
    end
    wr(6'h05, 8'hFF);
    wr(6'h1F, 8'hFF);
    rd(6'h05, d); chk("R10", "unmapped 0x05", 64'(d), 64'h00);
    rd(6'h1F, d); chk("R10", "unmapped 0x1F", 64'(d), 64'h00);
    rd(6'h18, d); chk("R10", "unmapped 0x18", 64'(d), 64'h00);
    rd(6'h1E, d); chk("R10", "last clock byte untouched", 64'(d), 64'hA5);
    chk("R10", "no pulse from unmapped", 64'(board_rst), 64'd0);
  endtask

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    phys_sw = 64'hDEAD_BEEF_0F1E_2D3C;
    idle(3);
    rst_n = 1'b1;
    idle(5);
    t_reset_state();
    t_ident();
    t_map();
    t_mux(64'hFFFF_0000_AAAA_5555, 64'h0000_0000_0000_0000, 64'h1234_5678_9ABC_DEF0);
    t_mux(64'hFFFF_0000_AAAA_5555, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0);
    t_mux(64'hFFFF_0000_AAAA_5555, 64'h0F0F_A5A5_F00F_3CC3, 64'h1234_5678_9ABC_DEF0);
    t_mux(64'h0123_4567_89AB_CDEF, 64'h8001_4002_2004_1008, 64'hFEDC_BA98_7654_3210);
    t_sync();
    t_boot_paths();
    t_retrigger();
    t_clk_and_unmapped();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule